// File: doc/BRIEF.md
# Paged Flash Erase Sequencer

This block erases a run of pages in a serial paged flash device. It works through a byte-level SPI master that shifts one byte at a time. A request gives a start page index, a page count, the shift that turns a page index into a device address, and an idle gap to insert between status polls. The request also carries the byte residues of the start offset and of the length within a page. A nonzero residue means the request is not page aligned, and the block rejects it before any SPI traffic.

At each step the sequencer picks one of two erases. It uses an eight-page block erase when the current page index sits on an eight-page boundary and at least eight pages remain. Otherwise it uses a single-page erase. It sends a four-byte erase frame and releases chip select. It then polls the device status until the ready bit is set, and steps forward by the number of pages it just erased.

The SPI master is a separate block. The sequencer holds `spi_req` with a byte on `spi_tx`. The master answers each byte with a one-cycle `spi_ack` and the byte it shifted in on `spi_rx`. The sequencer drives chip select itself.

Top module: `erase_sequencer`

## Requirements
- R1: If `start_rem` or `len_rem` is nonzero when a request is accepted, the block finishes in the next cycle. It raises `done` with `err` = 2'b01 and never asserts chip select for that request. The alignment check takes priority over a zero page count.
- R2: An aligned request with `page_count` = 0 finishes in the next cycle with `err` = 2'b00 and no chip-select activity.
- R3: An erase frame uses opcode 0x50 when the current page index has its low three bits zero and at least 8 pages remain. Every other erase frame uses opcode 0x81.
- R4: An erase frame is exactly four bytes sent in this order: the opcode, address bits [23:16], address bits [15:8], then 0x00. The address is (page index << `page_shift`) modulo 2^24.
- R5: After a ready poll, a block erase advances the page index by 8 and reduces the remaining count by 8; a page erase advances and reduces by 1. The run ends with `err` = 2'b00 once the remaining count reaches zero.
- R6: Before every status poll, chip select stays high for exactly `poll_gap`+1 cycles. A poll frame is two bytes, 0xD7 then 0x00. Only bit 7 of the second returned byte is examined, and a 1 means ready. A poll that returns not-ready is followed by another gap and another poll.
- R7: A poll that completes not-ready after at least TMO_CYCLES cycles since the end of the erase frame ends the run with `err` = 2'b10.
- R8: `done` is a one-cycle pulse. `busy` is high from the cycle after an accepted start up to, but not including, the `done` cycle. `err` holds its value until the next accepted start. A start is accepted only while `busy` is low.
- R9: `spi_req` is only high while chip select (`spi_cs_n` low) is asserted. Chip select is released between any two frames, and after reset it is released and `err` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted when not busy |
| start_page | input | PAGE_W | First page index |
| start_rem | input | REM_W | Byte residue of the start offset within a page |
| page_count | input | CNT_W | Number of pages to erase |
| len_rem | input | REM_W | Byte residue of the length within a page |
| page_shift | input | SHIFT_W | Left shift from page index to device address |
| poll_gap | input | GAP_W | Extra idle cycles before each status poll |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 none, 1 misaligned, 2 timeout |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_req | output | 1 | Byte exchange request |
| spi_tx | output | 8 | Byte to send |
| spi_ack | input | 1 | One-cycle byte-complete pulse from the SPI master |
| spi_rx | input | 8 | Byte received with `spi_ack` |

## Verification
The bench sweeps every start page from 0 to 11 against every page count from 0 to 15. Shift, gap, SPI latency and the number of busy polls all rotate across the sweep. This separates runs that begin on a block boundary from runs that do not. It also separates a remaining count just under eight from one that takes a block erase, and a misaligned head that takes page erases before the first block. One start near the top of the page range, with the largest shift, shows that the address truncates to 24 bits. Separate runs cover a residue in the offset, in the length, and in both, including a misaligned request with a zero count. A run with a device that never becomes ready checks the timeout path. The not-ready status byte has its low seven bits set, so any decode beyond bit 7 would show.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_CMD,
        ST_GAP,
        ST_POLL
    } seq_state_e;

    localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
    localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
    localparam logic [7:0] OP_STATUS      = 8'hD7;

    localparam int BLOCK_PAGES = 8;

    localparam logic [1:0] ERR_NONE  = 2'd0;
    localparam logic [1:0] ERR_ALIGN = 2'd1;
    localparam logic [1:0] ERR_TMO   = 2'd2;

endpackage

// File: rtl/erase_step_plan.sv
module erase_step_plan
    import erase_seq_pkg::*;
#(
    parameter int PAGE_W  = 16,
    parameter int CNT_W   = 16,
    parameter int SHIFT_W = 4
) (
    input  logic [PAGE_W-1:0]  page,
    input  logic [CNT_W-1:0]   remaining,
    input  logic [SHIFT_W-1:0] shift,
    output logic [7:0]         opcode,
    output logic [15:0]        addr_hi,
    output logic [CNT_W-1:0]   step
);
    localparam int SUM_W  = PAGE_W + (1 << SHIFT_W);
    localparam int WIDE_W = (SUM_W > 24) ? SUM_W : 24;

    logic use_block;

    // block erase only on an eight-page boundary with a full block left
    assign use_block = (page[2:0] == 3'd0) && (remaining >= CNT_W'(BLOCK_PAGES));
    assign opcode    = use_block ? OP_BLOCK_ERASE : OP_PAGE_ERASE;
    assign step      = use_block ? CNT_W'(BLOCK_PAGES) : CNT_W'(1);
    // address bits [23:8]; bit 7..0 of the frame is always zero
    assign addr_hi   = 16'((WIDE_W'(page) << shift) >> 8);

endmodule

// File: rtl/erase_byte_mux.sv
module erase_byte_mux
    import erase_seq_pkg::*;
(
    input  logic        poll_phase,
    input  logic [1:0]  idx,
    input  logic [7:0]  opcode,
    input  logic [15:0] addr_hi,
    output logic [7:0]  tx_byte
);
    always_comb begin
        if (poll_phase) begin
            tx_byte = (idx == 2'd0) ? OP_STATUS : 8'h00;
        end else begin
            unique case (idx)
                2'd0:    tx_byte = opcode;
                2'd1:    tx_byte = addr_hi[15:8];
                2'd2:    tx_byte = addr_hi[7:0];
                default: tx_byte = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/erase_sequencer.sv
module erase_sequencer
    import erase_seq_pkg::*;
#(
    parameter int PAGE_W     = 16,
    parameter int CNT_W      = 16,
    parameter int REM_W      = 11,
    parameter int SHIFT_W    = 4,
    parameter int GAP_W      = 8,
    parameter int TMO_CYCLES = 1000000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [PAGE_W-1:0]  start_page,
    input  logic [REM_W-1:0]   start_rem,
    input  logic [CNT_W-1:0]   page_count,
    input  logic [REM_W-1:0]   len_rem,
    input  logic [SHIFT_W-1:0] page_shift,
    input  logic [GAP_W-1:0]   poll_gap,
    output logic               busy,
    output logic               done,
    output logic [1:0]         err,
    output logic               spi_cs_n,
    output logic               spi_req,
    output logic [7:0]         spi_tx,
    input  logic               spi_ack,
    input  logic [7:0]         spi_rx
);
    localparam int TMO_W = $clog2(TMO_CYCLES + 1);
    localparam logic [TMO_W-1:0] TMO_LIMIT = TMO_W'(TMO_CYCLES);

    typedef struct packed {
        seq_state_e         state;
        logic [PAGE_W-1:0]  page;
        logic [CNT_W-1:0]   remaining;
        logic [SHIFT_W-1:0] shift;
        logic [GAP_W-1:0]   gap_len;
        logic [GAP_W-1:0]   gap;
        logic [TMO_W-1:0]   tmo;
        logic [1:0]         idx;
        logic [7:0]         opcode;
        logic [15:0]        addr_hi;
        logic [CNT_W-1:0]   step;
        logic               done;
        logic [1:0]         err;
    } seq_regs_t;

    seq_regs_t q, d;

    logic [7:0]       plan_op;
    logic [15:0]      plan_addr;
    logic [CNT_W-1:0] plan_step;
    logic             frame_on;
    logic             rx_low_unused;

    assign rx_low_unused = ^spi_rx[6:0];

    erase_step_plan #(
        .PAGE_W (PAGE_W),
        .CNT_W  (CNT_W),
        .SHIFT_W(SHIFT_W)
    ) u_plan (
        .page     (q.page),
        .remaining(q.remaining),
        .shift    (q.shift),
        .opcode   (plan_op),
        .addr_hi  (plan_addr),
        .step     (plan_step)
    );

    erase_byte_mux u_mux (
        .poll_phase(q.state == ST_POLL),
        .idx       (q.idx),
        .opcode    (q.opcode),
        .addr_hi   (q.addr_hi),
        .tx_byte   (spi_tx)
    );

    assign frame_on = (q.state == ST_CMD) || (q.state == ST_POLL);
    assign spi_cs_n = !frame_on;
    assign spi_req  = frame_on;
    assign busy     = (q.state != ST_IDLE);
    assign done     = q.done;
    assign err      = q.err;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    if ((start_rem != '0) || (len_rem != '0)) begin
                        d.done = 1'b1;
                        d.err  = ERR_ALIGN;
                    end else if (page_count == '0) begin
                        d.done = 1'b1;
                        d.err  = ERR_NONE;
                    end else begin
                        d.err       = ERR_NONE;
                        d.page      = start_page;
                        d.remaining = page_count;
                        d.shift     = page_shift;
                        d.gap_len   = poll_gap;
                        d.state     = ST_PLAN;
                    end
                end
            end
            ST_PLAN: begin
                d.opcode  = plan_op;
                d.addr_hi = plan_addr;
                d.step    = plan_step;
                d.idx     = 2'd0;
                d.state   = ST_CMD;
            end
            ST_CMD: begin
                if (spi_ack) begin
                    d.idx = q.idx + 2'd1;
                    if (q.idx == 2'd3) begin
                        d.state = ST_GAP;
                        d.gap   = q.gap_len;
                        d.tmo   = '0;
                    end
                end
            end
            ST_GAP: begin
                if (q.tmo < TMO_LIMIT) d.tmo = q.tmo + 1'b1;
                if (q.gap == '0) begin
                    d.state = ST_POLL;
                    d.idx   = 2'd0;
                end else begin
                    d.gap = q.gap - 1'b1;
                end
            end
            ST_POLL: begin
                if (q.tmo < TMO_LIMIT) d.tmo = q.tmo + 1'b1;
                if (spi_ack) begin
                    if (q.idx == 2'd0) begin
                        d.idx = 2'd1;
                    end else if (spi_rx[7]) begin
                        d.page      = q.page + PAGE_W'(q.step);
                        d.remaining = q.remaining - q.step;
                        if (q.remaining == q.step) begin
                            d.state = ST_IDLE;
                            d.done  = 1'b1;
                            d.err   = ERR_NONE;
                        end else begin
                            d.state = ST_PLAN;
                        end
                    end else if (q.tmo >= TMO_LIMIT) begin
                        d.state = ST_IDLE;
                        d.done  = 1'b1;
                        d.err   = ERR_TMO;
                    end else begin
                        d.state = ST_GAP;
                        d.gap   = q.gap_len;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R9: a byte request only inside an open frame
    assert_req_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req |-> !spi_cs_n);

    // R8: done never lasts two cycles
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: a misaligned request ends at once with no frame
    assert_misalign_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && ((start_rem != '0) || (len_rem != '0)))
        |=> (done && err == ERR_ALIGN && spi_cs_n && !busy));

    // R2: an empty aligned request ends at once with no frame
    assert_empty_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && start_rem == '0 && len_rem == '0 && page_count == '0)
        |=> (done && err == ERR_NONE && spi_cs_n && !busy));

    // R6: chip select released right after the last erase byte
    assert_release_after_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_CMD && spi_ack && q.idx == 2'd3) |=> spi_cs_n);

    // R7: a timeout report follows a not-ready status byte
    assert_tmo_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err == ERR_TMO) |-> !$past(spi_rx[7]));

endmodule

// File: tb/erase_sequencer_bench.sv
`timescale 1ns/1ps
module erase_sequencer_bench;
    localparam int TMO = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] start_page = '0;
    logic [10:0] start_rem = '0;
    logic [15:0] page_count = '0;
    logic [10:0] len_rem = '0;
    logic [3:0]  page_shift = '0;
    logic [7:0]  poll_gap = '0;
    logic        busy, done;
    logic [1:0]  err;
    logic        spi_cs_n, spi_req;
    logic [7:0]  spi_tx;
    logic        spi_ack = 1'b0;
    logic [7:0]  spi_rx = '0;

    always #2.5 clk = ~clk;

    erase_sequencer #(.TMO_CYCLES(TMO)) u_erase_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .start_page(start_page),
        .start_rem(start_rem), .page_count(page_count), .len_rem(len_rem),
        .page_shift(page_shift), .poll_gap(poll_gap), .busy(busy), .done(done),
        .err(err), .spi_cs_n(spi_cs_n), .spi_req(spi_req), .spi_tx(spi_tx),
        .spi_ack(spi_ack), .spi_rx(spi_rx)
    );

    int checks = 0;
    int fails = 0;

    // device / master model state
    int ncmd, npoll, ntxn, bad_frame, bad_gap, done_cnt;
    int lat, polls_left, busy_polls, exp_gap;
    int hi_run, last_run, txn_len;
    bit in_txn;
    logic [7:0] txn_buf [0:7];
    logic [7:0] cmd_log [0:31][0:3];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_txn();
        ntxn++;
        if (txn_buf[0] == 8'hD7) begin
            npoll++;
            if (txn_len != 2 || txn_buf[1] != 8'h00) bad_frame++;
            if (last_run != exp_gap) bad_gap++;
        end else begin
            if (ncmd < 32) begin
                for (int i = 0; i < 4; i++) cmd_log[ncmd][i] = txn_buf[i];
            end
            if (txn_len != 4) bad_frame++;
            ncmd++;
            polls_left = busy_polls;
        end
    endtask

    // SPI master and device model
    initial begin
        in_txn = 0; hi_run = 0; last_run = 0; txn_len = 0;
        forever begin
            @(negedge clk);
            spi_ack = 1'b0;
            if (done) done_cnt++;
            if (spi_cs_n) begin
                if (in_txn) begin
                    finish_txn();
                    in_txn = 0;
                end
                hi_run++;
            end else begin
                if (!in_txn) begin
                    in_txn = 1; txn_len = 0; last_run = hi_run; hi_run = 0;
                end
                if (spi_req) begin
                    if (txn_len < 8) txn_buf[txn_len] = spi_tx;
                    repeat (lat) @(negedge clk);
                    if (txn_len == 1 && txn_buf[0] == 8'hD7) begin
                        if (polls_left > 0) begin
                            spi_rx = 8'h7F;
                            polls_left--;
                        end else begin
                            spi_rx = 8'h80;
                        end
                    end else begin
                        spi_rx = 8'hFF;
                    end
                    txn_len++;
                    spi_ack = 1'b1;
                end
            end
        end
    end

    task automatic run_case(input int sp, input int cnt, input int sh, input int gap,
                            input int bp, input int l, input int sr, input int lr,
                            input int exp_err, input string etag);
        int w;
        int p, n, k, expn;
        bit blk;
        ncmd = 0; npoll = 0; ntxn = 0; bad_frame = 0; bad_gap = 0; done_cnt = 0;
        busy_polls = bp; polls_left = bp; lat = l; exp_gap = gap + 1;
        @(negedge clk);
        start = 1'b1; start_page = 16'(sp); page_count = 16'(cnt);
        page_shift = 4'(sh); poll_gap = 8'(gap);
        start_rem = 11'(sr); len_rem = 11'(lr);
        @(negedge clk);
        start = 1'b0;
        if (exp_err == 1 || cnt == 0)
            chk(done == 1'b1, "R1/R2 immediate done", done, 1);
        else
            chk(busy == 1'b1, "R8 busy after start", busy, 1);
        w = 0;
        while (!done && w < 20000) begin
            @(negedge clk);
            w++;
        end
        chk(w < 20000, "R8 done reached", w, 0);
        chk(busy == 1'b0, "R8 busy low at done", busy, 0);
        repeat (2) @(negedge clk);
        chk(err == 2'(exp_err), etag, err, exp_err);
        chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
        chk(bad_frame == 0, "R4/R6 frame shape", bad_frame, 0);
        chk(bad_gap == 0, "R6 gap before poll", bad_gap, 0);
        if (exp_err == 1 || cnt == 0) begin
            chk(ntxn == 0, "R1/R2 no traffic", ntxn, 0);
            return;
        end
        // expected erase sequence
        p = sp; n = cnt; k = 0;
        expn = 0;
        while (n > 0) begin
            blk = (p % 8 == 0) && (n >= 8);
            expn++;
            if (k < ncmd && k < 32) begin
                int a;
                a = (p << sh) & 24'hFFFFFF;
                chk(cmd_log[k][0] == (blk ? 8'h50 : 8'h81), "R3 opcode", cmd_log[k][0], blk ? 8'h50 : 8'h81);
                chk(cmd_log[k][1] == 8'(a >> 16), "R4 addr[23:16]", cmd_log[k][1], (a >> 16) & 8'hFF);
                chk(cmd_log[k][2] == 8'(a >> 8), "R4 addr[15:8]", cmd_log[k][2], (a >> 8) & 8'hFF);
                chk(cmd_log[k][3] == 8'h00, "R4 zero byte", cmd_log[k][3], 0);
            end
            k++;
            p = (p + (blk ? 8 : 1)) & 16'hFFFF;
            n = n - (blk ? 8 : 1);
            if (exp_err == 2) n = 0;
        end
        chk(ncmd == expn, "R5 erase frame count", ncmd, expn);
        if (exp_err == 2)
            chk(npoll >= 1, "R7 polled before timeout", npoll, 1);
        else
            chk(npoll == expn * (bp + 1), "R6 poll count", npoll, expn * (bp + 1));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R8 run did not end actual=0x0 expected=0x1");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R9 cs idle in reset", spi_cs_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R8 idle after reset", {busy, done}, 0);
        chk(spi_cs_n == 1'b1 && spi_req == 1'b0, "R9 no frame after reset", {spi_cs_n, spi_req}, 2);
        chk(err == 2'd0, "R9 err clear after reset", err, 0);

        for (int sp = 0; sp < 12; sp++) begin
            for (int cnt = 0; cnt < 16; cnt++) begin
                run_case(sp, cnt, 9 + (sp % 3), cnt % 4, (sp + cnt) % 3, cnt % 3,
                         0, 0, 0, cnt == 0 ? "R2 empty err" : "R5 run err");
            end
        end
        // address truncation to 24 bits
        run_case(16'hFFF8, 9, 11, 1, 0, 1, 0, 0, 0, "R4 wrap err");
        // misaligned requests
        run_case(4, 3, 9, 0, 0, 0, 5, 0, 1, "R1 offset residue err");
        run_case(4, 3, 9, 0, 0, 0, 0, 1, 1, "R1 length residue err");
        run_case(8, 16, 10, 0, 0, 0, 7, 9, 1, "R1 both residues err");
        run_case(0, 0, 9, 0, 0, 0, 3, 0, 1, "R1 residue beats zero count err");
        // device never ready
        run_case(3, 2, 9, 2, 1000000, 1, 0, 0, 2, "R7 timeout err");
        // normal run after a timeout
        run_case(8, 9, 9, 0, 1, 0, 0, 0, 0, "R8 recovery err");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule